// File: doc/BRIEF.md
# Iterative BCD-to-Binary Converter

This block turns a packed two-digit decimal value into its plain binary equivalent over several clock cycles. It runs the shift-and-add-3 method backwards. A scratch value made of the decimal digits and a growing binary field is shifted right one bit per cycle. After each shift, any digit that reads 8 or more has 3 taken off. Once one step per output bit has run, the binary field holds the result.

A small three-state controller (idle, run, done) sits in front of the datapath. A start pulse seen in idle captures the digits and clears the binary field. The run state then counts down one step per output bit. The done state raises a one-cycle completion flag while the new result is shown, and then returns to idle. The result stays on the output until the next conversion finishes. The block does not check whether the digit codes are valid BCD. Codes above 9 give an undefined value, but the conversion still ends on time.

Top module: `bcd2bin_conv`

## Requirements
- R1: For tens digit `bcdI[7:4]` and units digit `bcdI[3:0]`, both in 0..9, the result equals 10*tens + units.
- R2: `doneO` rises on the seventh rising edge after the edge that samples `startI` high in idle, which is one step per output bit.
- R3: `doneO` is high for exactly one cycle. The machine is then idle, so a start pulse in the very next cycle begins a new conversion.
- R4: `startI` has no effect outside idle. A pulse during the run or done cycles neither changes the pending result nor produces an extra `doneO`.
- R5: `resultO` changes only in the cycle where `doneO` is high. Otherwise it keeps the last result.
- R6: A synchronous reset, including one in the middle of a conversion, leaves the block idle with `doneO` low and `resultO` zero.
- R7: Digit codes above 9 still finish with `doneO` at the R2 latency, and a later valid conversion is correct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| startI | input | 1 | Start strobe, sampled only in idle |
| bcdI | input | 8 | Packed digits, tens in [7:4], units in [3:0] |
| doneO | output | 1 | One-cycle completion flag |
| resultO | output | 7 | Binary result, held between conversions |

## Verification
The bench builds the block with its default parameters: two digits and a seven-bit result. At this size the full set of 100 valid digit pairs can be swept exhaustively, each started in the idle cycle right after the previous done. The default width also keeps the fixed seven-step latency short enough to check on every conversion. Invalid codes such as 0xFF, stray start pulses in the run and done states, and a reset in the middle of a conversion are all cheap to reach at this width.

// File: rtl/bcd2bin_pkg.sv
package bcd2bin_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } convState_t;

  typedef struct packed {
    logic load;  // capture digits, clear binary field
    logic step;  // one reverse shift-and-correct step
    logic last;  // final step: publish result
  } dpCtrl_t;
endpackage

// File: rtl/bcd2bin_ctrl.sv
module bcd2bin_ctrl
  import bcd2bin_pkg::*;
#(
  parameter int BIN_W = 7
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    startI,
  output dpCtrl_t ctrlO,
  output logic    doneO
);
  localparam int CNT_W = $clog2(BIN_W + 1);

  convState_t stateQ;
  logic [CNT_W-1:0] cntQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      stateQ <= ST_IDLE;
      cntQ   <= '0;
    end else begin
      case (stateQ)
        ST_IDLE: if (startI) begin
          stateQ <= ST_RUN;
          cntQ   <= CNT_W'(BIN_W);
        end
        ST_RUN: begin
          cntQ <= cntQ - 1'b1;
          if (cntQ == CNT_W'(1)) stateQ <= ST_DONE;
        end
        ST_DONE: stateQ <= ST_IDLE;
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctrlO.load = (stateQ == ST_IDLE) && startI;
    ctrlO.step = (stateQ == ST_RUN);
    ctrlO.last = (stateQ == ST_RUN) && (cntQ == CNT_W'(1));
    doneO      = (stateQ == ST_DONE);
  end

  assert_run_count_R2: assert property (@(posedge clk) disable iff (rst)
    (stateQ == ST_RUN) |-> (cntQ != '0));

  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    (stateQ == ST_DONE) |=> (stateQ == ST_IDLE));

  assert_start_ignored_R4: assert property (@(posedge clk) disable iff (rst)
    (stateQ == ST_RUN && cntQ > CNT_W'(1)) |=> (stateQ == ST_RUN));

  assert_run_finishes_R7: assert property (@(posedge clk) disable iff (rst)
    (stateQ == ST_RUN && cntQ == CNT_W'(1)) |=> (stateQ == ST_DONE));
endmodule

// File: rtl/bcd2bin_dp.sv
module bcd2bin_dp
  import bcd2bin_pkg::*;
#(
  parameter int DIGITS = 2,
  parameter int BIN_W  = 7
) (
  input  logic                  clk,
  input  logic                  rst,
  input  dpCtrl_t               ctrlI,
  input  logic [4*DIGITS-1:0]   bcdI,
  output logic [BIN_W-1:0]      resultO
);
  logic [3:0] digQ [DIGITS];
  logic [BIN_W-1:0] binQ, binD, resQ;

  for (genvar g = 0; g < DIGITS; g++) begin : gDigit
    logic [3:0] shifted, corrected;
    if (g == DIGITS - 1) begin : gTop
      assign shifted = {1'b0, digQ[g][3:1]};
    end else begin : gMid
      assign shifted = {digQ[g+1][0], digQ[g][3:1]};
    end
    assign corrected = (shifted >= 4'd8) ? (shifted - 4'd3) : shifted;

    always_ff @(posedge clk) begin
      if (rst)             digQ[g] <= '0;
      else if (ctrlI.load) digQ[g] <= bcdI[4*g +: 4];
      else if (ctrlI.step) digQ[g] <= corrected;
    end
  end

  assign binD = {digQ[0][0], binQ[BIN_W-1:1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      binQ <= '0;
      resQ <= '0;
    end else begin
      if (ctrlI.load)      binQ <= '0;
      else if (ctrlI.step) binQ <= binD;
      if (ctrlI.step && ctrlI.last) resQ <= binD;
    end
  end

  assign resultO = resQ;

  assert_clear_on_load_R1: assert property (@(posedge clk) disable iff (rst)
    ctrlI.load |=> (binQ == '0));

  assert_result_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !ctrlI.last |=> $stable(resQ));
endmodule

// File: rtl/bcd2bin_conv.sv
module bcd2bin_conv
  import bcd2bin_pkg::*;
#(
  parameter int DIGITS = 2,
  parameter int BIN_W  = 7
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                startI,
  input  logic [4*DIGITS-1:0] bcdI,
  output logic                doneO,
  output logic [BIN_W-1:0]    resultO
);
  dpCtrl_t ctrlBus;

  bcd2bin_ctrl #(.BIN_W(BIN_W)) u_ctrl (
    .clk(clk), .rst(rst), .startI(startI), .ctrlO(ctrlBus), .doneO(doneO)
  );

  bcd2bin_dp #(.DIGITS(DIGITS), .BIN_W(BIN_W)) u_dp (
    .clk(clk), .rst(rst), .ctrlI(ctrlBus), .bcdI(bcdI), .resultO(resultO)
  );

  assert_reset_clears_R6: assert property (@(posedge clk)
    rst |=> (!doneO && resultO == '0));
endmodule

// File: tb/bcd2bin_conv_bench.sv
module bcd2bin_conv_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [7:0] bcd = '0;
  logic done;
  logic [6:0] res;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 0;
  int qVal[$];
  int qCyc[$];
  bit qCare[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  bcd2bin_conv u_bcd2bin_conv (
    .clk(clk), .rst(rst), .startI(start), .bcdI(bcd), .doneO(done), .resultO(res)
  );

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // driver: push expected value and done cycle, pulse start
  task automatic startConv(int t, int u, bit care);
    @(negedge clk);
    bcd = {t[3:0], u[3:0]};
    start = 1'b1;
    qVal.push_back(t * 10 + u);
    qCyc.push_back(cyc + 8);
    qCare.push_back(care);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitDone();
    do @(negedge clk); while (!done);
  endtask

  // monitor / scoreboard
  initial begin
    int lastRes, ev, ec;
    bit care, prevDone;
    lastRes = 0;
    prevDone = 0;
    forever begin
      @(negedge clk);
      if (rst) begin
        prevDone = 0;
        lastRes = 0;
      end else begin
        if (done) begin
          check(!prevDone, "R3 done longer than one cycle", 1, 0);
          if (qVal.size() == 0) check(0, "R4 unexpected done", 1, 0);
          else begin
            ev = qVal.pop_front();
            ec = qCyc.pop_front();
            care = qCare.pop_front();
            check(cyc == ec, "R2 done latency (R7 for invalid codes)", cyc, ec);
            if (care) check(res == 7'(ev), "R1 converted value", int'(res), ev);
          end
          lastRes = int'(res);
        end else if (res !== 7'(lastRes)) begin
          check(0, "R5 result changed without done", int'(res), lastRes);
          lastRes = int'(res);
        end
        prevDone = done;
      end
    end
  end

  initial begin
    // R6: reset state
    repeat (3) @(negedge clk);
    check(done == 1'b0, "R6 done after reset", int'(done), 0);
    check(res == 7'd0, "R6 result after reset", int'(res), 0);
    rst = 1'b0;

    // R1, R2, R3: every valid pair, back to back
    for (int t = 0; t < 10; t++)
      for (int u = 0; u < 10; u++) begin
        startConv(t, u, 1'b1);
        waitDone();
      end

    // R4: start during run and during done is ignored
    startConv(4, 2, 1'b1);
    @(negedge clk); bcd = 8'h33; start = 1'b1;
    @(negedge clk); start = 1'b0;
    waitDone();
    bcd = 8'h11; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (12) @(negedge clk);
    check(qVal.size() == 0, "R4 pending items after ignored starts", qVal.size(), 0);
    check(res == 7'd42, "R4 R5 result held after ignored starts", int'(res), 42);

    // R7: invalid codes still finish, then valid conversion recovers
    startConv(15, 15, 1'b0);
    waitDone();
    startConv(10, 0, 1'b0);
    waitDone();
    startConv(9, 9, 1'b1);
    waitDone();
    check(res == 7'd99, "R7 recovery after invalid codes", int'(res), 99);

    // R6: reset in the middle of a conversion
    startConv(5, 7, 1'b1);
    repeat (3) @(negedge clk);
    rst = 1'b1;
    qVal.delete(); qCyc.delete(); qCare.delete();
    @(negedge clk);
    check(done == 1'b0, "R6 done after mid-run reset", int'(done), 0);
    check(res == 7'd0, "R6 result after mid-run reset", int'(res), 0);
    rst = 1'b0;
    repeat (12) @(negedge clk);
    check(done == 1'b0 && res == 7'd0, "R6 idle after mid-run reset", int'(res), 0);

    // R3: start right after done on a fresh run
    startConv(0, 1, 1'b1);
    waitDone();
    startConv(6, 4, 1'b1);
    waitDone();
    @(negedge clk);
    check(qVal.size() == 0, "R3 all conversions completed", qVal.size(), 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog R2 actual %0d expected %0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule